// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block turns bytes into asynchronous serial characters on an idle-high line. Bytes enter a small first-in first-out queue through a one-cycle write strobe. A framing engine takes them one at a time and sends a start bit, 5 to 8 data bits (least significant first), an optional parity bit and a stop interval whose length is set in sixteenths of a bit. Bit timing comes from a 16x baud enable supplied from outside. One bit lasts sixteen of those enables.

Two flow-control features sit beside the framer. A clear-to-send input, when its check is switched on, is looked at only when a new character would begin. A character already on the line always runs to its end. The request-to-send output is pulled active (low) by a strobe. When automatic release is on, the block drives it inactive again one bit-time after the last character has fully left. The format inputs are captured when each character is launched, so a format change takes effect from the next character.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, txd, tx_ready, tx_empty and rts_n are all 1.
- R2: A character is a low start bit followed by the data bits, least significant first. Each bit lasts 16 tick16 pulses. fmt_len encodes the data length as 0=5, 1=6, 2=7, 3=8 bits.
- R3: With par_en=1, one parity bit follows the data. It is the XOR of the sent data bits when par_odd=0 and the inverse of that XOR when par_odd=1.
- R4: The line is held high after the last data or parity bit for a stop interval of 9+c ticks for stop_sel c in 0..7 and 17+c ticks for c in 8..15. A queued character that is allowed to go begins exactly at the end of that interval.
- R5: For 5-bit characters the stop interval is 8 ticks longer than R4 gives.
- R6: The queue holds DEPTH bytes in arrival order. tx_ready is 0 while it is full, and a write while full is dropped.
- R7: With cts_en=1, a character is launched only while cts_n is 0. A character already started completes when cts_n rises, and later ones wait until cts_n is 0 again.
- R8: With cts_en=0, cts_n has no effect on transmission.
- R9: tx_empty is 1 exactly when the queue is empty and no character (stop interval included) is in progress.
- R10: A pulse on rts_set drives rts_n to 0. With auto_rts_en=1, rts_n returns to 1 sixteen ticks after tx_empty rises. With auto_rts_en=0, it stays 0.
- R11: While tick16 is 0 the line does not change and no character starts.
- R12: Format inputs changed during a character do not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | 16x baud enable |
| wr_valid | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| fmt_len | input | 2 | Data length select (0..3 = 5..8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1 |
| stop_sel | input | 4 | Stop interval code |
| cts_en | input | 1 | Clear-to-send check enable |
| cts_n | input | 1 | Clear-to-send, active low |
| auto_rts_en | input | 1 | Automatic request-to-send release |
| rts_set | input | 1 | Strobe that asserts request-to-send |
| txd | output | 1 | Serial line |
| rts_n | output | 1 | Request-to-send, active low |
| tx_ready | output | 1 | Queue has space |
| tx_empty | output | 1 | Queue and framer idle |

## Verification
The end of one character's stop interval and the launch of the next character can fall in the same tick. The clear-to-send decision is taken in that same tick. Back-to-back bursts force this case: the bench measures the high run between frames and expects it to equal the programmed stop length with no gap. Clear-to-send is raised in the middle of a frame, and the bench then expects that frame to finish intact and the next one to be held. The release count for request-to-send is also judged against the exact cycle at which tx_empty rises at the end of the stop interval.

// File: rtl/uart_tx_flow_pkg.sv
package uart_tx_flow_pkg;

  localparam int OVS    = 16;  // ticks per bit
  localparam int DATA_W = 8;
  localparam int CNT_W  = 6;   // holds the longest stop interval (40 ticks)

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP
  } fr_state_t;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic [3:0] stop_sel;
  } fmt_t;

  // stop interval in ticks: low half of the code spans 9..16, high half 25..32,
  // plus half a bit for 5-bit characters
  function automatic logic [CNT_W-1:0] stop_ticks(input logic [3:0] sel,
                                                  input logic [1:0] len_sel);
    logic [CNT_W-1:0] t;
    t = {3'b000, sel[2:0]} + (sel[3] ? CNT_W'(2*OVS-7) : CNT_W'(OVS-7));
    if (len_sel == 2'd0) t = t + CNT_W'(OVS/2);
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len_sel);
    return {DATA_W{1'b1}} >> (2'd3 - len_sel);
  endfunction

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, count_nxt;
  logic          push_ok, pop_ok;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    count_nxt = count;
    if (push_ok && !pop_ok) count_nxt = count + CW'(1);
    else if (pop_ok && !push_ok) count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      count <= count_nxt;
      full  <= (count_nxt == CW'(DEPTH));
      empty <= (count_nxt == '0);
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_flow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  fmt_t              fmt,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              q_avail,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              txd,
  output logic              idle
);
  fr_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        bidx;
  logic [2:0]        last_q;
  logic [DATA_W-1:0] sh;
  logic              par_q;
  logic              par_en_q;
  logic [CNT_W-1:0]  stop_q;
  logic              bit_end, stop_end, clear, go;
  logic [DATA_W-1:0] masked;

  assign bit_end  = (cnt == CNT_W'(OVS-1));
  assign stop_end = (cnt == stop_q - CNT_W'(1));
  assign clear    = !cts_en || !cts_n;
  assign go       = tick && q_avail && clear &&
                    ((state == FR_IDLE) || ((state == FR_STOP) && stop_end));
  assign q_pop    = go;
  assign masked   = q_data & len_mask(fmt.len_sel);
  assign idle     = (state == FR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      txd      <= 1'b1;
      cnt      <= '0;
      bidx     <= '0;
      last_q   <= '0;
      sh       <= '0;
      par_q    <= 1'b0;
      par_en_q <= 1'b0;
      stop_q   <= CNT_W'(OVS);
    end else if (tick) begin
      if (go) begin
        state    <= FR_START;
        txd      <= 1'b0;
        cnt      <= '0;
        bidx     <= '0;
        sh       <= masked;
        par_q    <= (^masked) ^ fmt.par_odd;
        par_en_q <= fmt.par_en;
        last_q   <= {1'b0, fmt.len_sel} + 3'd4;
        stop_q   <= stop_ticks(fmt.stop_sel, fmt.len_sel);
      end else begin
        case (state)
          FR_IDLE: cnt <= '0;
          FR_START: begin
            if (bit_end) begin
              state <= FR_DATA;
              txd   <= sh[0];
              sh    <= sh >> 1;
              cnt   <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          FR_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              if (bidx == last_q) begin
                if (par_en_q) begin
                  state <= FR_PAR;
                  txd   <= par_q;
                end else begin
                  state <= FR_STOP;
                  txd   <= 1'b1;
                end
              end else begin
                bidx <= bidx + 3'd1;
                txd  <= sh[0];
                sh   <= sh >> 1;
              end
            end else cnt <= cnt + CNT_W'(1);
          end
          FR_PAR: begin
            if (bit_end) begin
              state <= FR_STOP;
              txd   <= 1'b1;
              cnt   <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          FR_STOP: begin
            if (stop_end) begin
              state <= FR_IDLE;
              cnt   <= '0;
            end else cnt <= cnt + CNT_W'(1);
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_rts.sv
module uart_tx_rts #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic set_req,
  input  logic auto_en,
  input  logic drained,
  output logic rts_n
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
      cnt   <= '0;
    end else if (set_req) begin
      rts_n <= 1'b0;
      cnt   <= '0;
    end else if (!drained || !auto_en || rts_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == HW'(HOLD-1)) begin
        rts_n <= 1'b1;
        cnt   <= '0;
      end else cnt <= cnt + HW'(1);
    end
  end
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_flow_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] fmt_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [3:0] stop_sel,
  input  logic       cts_en,
  input  logic       cts_n,
  input  logic       auto_rts_en,
  input  logic       rts_set,
  output logic       txd,
  output logic       rts_n,
  output logic       tx_ready,
  output logic       tx_empty
);
  fmt_t              fmt;
  logic [DATA_W-1:0] q_head;
  logic              q_full, q_empty, q_pop, fr_idle;

  assign fmt = '{len_sel: fmt_len, par_en: par_en, par_odd: par_odd, stop_sel: stop_sel};

  uart_tx_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_valid),
    .push_data (wr_data),
    .pop       (q_pop),
    .head      (q_head),
    .full      (q_full),
    .empty     (q_empty)
  );

  uart_tx_framer u_framer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .fmt     (fmt),
    .cts_en  (cts_en),
    .cts_n   (cts_n),
    .q_avail (!q_empty),
    .q_data  (q_head),
    .q_pop   (q_pop),
    .txd     (txd),
    .idle    (fr_idle)
  );

  assign tx_ready = !q_full;
  assign tx_empty = q_empty && fr_idle;

  uart_tx_rts #(.HOLD(OVS)) u_rts (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick16),
    .set_req (rts_set),
    .auto_en (auto_rts_en),
    .drained (tx_empty),
    .rts_n   (rts_n)
  );
endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk,
  input logic rst,
  input logic tick16,
  input logic txd,
  input logic tx_ready,
  input logic tx_empty,
  input logic cts_en,
  input logic cts_n,
  input logic rts_n,
  input logic auto_rts_en,
  input logic q_pop,
  input logic q_empty
);
  AST_START_AFTER_POP: assert property (@(posedge clk) disable iff (rst)
    q_pop |=> !txd); // R2
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> !q_empty); // R6
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |-> !tx_empty); // R6
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
    (q_pop && cts_en) |-> !cts_n); // R7
  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd); // R9
  AST_RTS_AUTO_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(rts_n)) |-> $past(auto_rts_en)); // R10
  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick16)) |-> $stable(txd)); // R11
endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick16      (tick16),
  .txd         (txd),
  .tx_ready    (tx_ready),
  .tx_empty    (tx_empty),
  .cts_en      (cts_en),
  .cts_n       (cts_n),
  .rts_n       (rts_n),
  .auto_rts_en (auto_rts_en),
  .q_pop       (q_pop),
  .q_empty     (q_empty)
);

// File: tb/uart_tx_flow_test.sv
module uart_tx_flow_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] fmt_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [3:0] stop_sel = 4'd7;
  logic       cts_en = 1'b0;
  logic       cts_n = 1'b0;
  logic       auto_rts_en = 1'b0;
  logic       rts_set = 1'b0;
  logic       txd, rts_n, tx_ready, tx_empty;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q [0:255];
  int wi = 0;
  int rd_i = 0;

  always #5 clk = ~clk;

  uart_tx_flow #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_valid(wr_valid), .wr_data(wr_data),
    .fmt_len(fmt_len), .par_en(par_en), .par_odd(par_odd), .stop_sel(stop_sel),
    .cts_en(cts_en), .cts_n(cts_n), .auto_rts_en(auto_rts_en), .rts_set(rts_set),
    .txd(txd), .rts_n(rts_n), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int exp_stop(input logic [3:0] c, input int nb);
    int t;
    t = (c < 8) ? 9 + int'(c) : 17 + int'(c);
    if (nb == 5) t += 8;
    return t;
  endfunction

  function automatic logic [7:0] nb_mask(input int nb);
    return 8'hFF >> (8 - nb);
  endfunction

  // serial line monitor: positioned at the first low sample of a start bit
  task automatic decode_frame();
    int nb, run, sc;
    bit pe, po, followed;
    logic [7:0] d, e;
    logic pb, pexp;
    nb = 5 + int'(fmt_len); pe = par_en; po = par_odd; sc = int'(stop_sel);
    d = '0; pb = 1'b0;
    repeat (7) @(negedge clk);
    chk(txd === 1'b0, "R2 start bit", int'(txd), 0);
    for (int j = 0; j < nb; j++) begin
      repeat (16) @(negedge clk);
      d[j] = txd;
    end
    if (pe) begin
      repeat (16) @(negedge clk);
      pb = txd;
    end
    repeat (9) @(negedge clk);
    run = 0;
    while (txd === 1'b1 && run < 64) begin
      run++;
      @(negedge clk);
    end
    followed = (txd === 1'b0);
    if (rd_i >= wi) begin
      chk(1'b0, "R6 unexpected frame", int'(d), -1);
    end else begin
      e = exp_q[rd_i] & nb_mask(nb);
      chk(d == e, "R2 data bits", int'(d), int'(e));
      if (pe) begin
        pexp = (^e) ^ po;
        chk(pb == pexp, "R3 parity", int'(pb), int'(pexp));
      end
      if (followed)
        chk(run == exp_stop(4'(sc), nb), (nb == 5) ? "R5 stop length" : "R4 stop length",
            run, exp_stop(4'(sc), nb));
      else
        chk(run >= exp_stop(4'(sc), nb), (nb == 5) ? "R5 stop min" : "R4 stop min",
            run, exp_stop(4'(sc), nb));
    end
    rd_i++;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (!rst && txd === 1'b0) decode_frame();
    end
  end

  task automatic push_burst(input int n, input bit rnd, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = rnd ? 8'($urandom) : base + 8'(i);
      exp_q[wi] = wr_data;
      wi++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (tx_empty !== 1'b1);
    repeat (70) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin : stim
    int base, seed, burst_ok;
    logic [3:0] codes [0:3];
    seed = $urandom(32'd2024);
    codes[0] = 4'd0; codes[1] = 4'd7; codes[2] = 4'd8; codes[3] = 4'd15;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(tx_empty == 1'b1, "R1 tx_empty", int'(tx_empty), 1);
    chk(rts_n == 1'b1, "R1 rts_n", int'(rts_n), 1);

    // R4: stop codes at both ends of both halves, 8-bit back-to-back
    for (int k = 0; k < 4; k++) begin
      stop_sel = codes[k];
      push_burst(2, 1'b1, 8'h00);
      wait_done();
    end
    // R5: 5-bit characters add half a bit
    fmt_len = 2'd0;
    stop_sel = 4'd0;  push_burst(2, 1'b1, 8'h00); wait_done();
    stop_sel = 4'd15; push_burst(2, 1'b1, 8'h00); wait_done();
    // R3: both parity senses
    fmt_len = 2'd3; par_en = 1'b1; stop_sel = 4'd7;
    par_odd = 1'b0; push_burst(2, 1'b0, 8'h5A); wait_done();
    par_odd = 1'b1; push_burst(2, 1'b0, 8'h5A); wait_done();

    // random formats
    for (int p = 0; p < 8; p++) begin
      fmt_len  = 2'($urandom);
      par_en   = 1'($urandom);
      par_odd  = 1'($urandom);
      stop_sel = 4'($urandom);
      push_burst(3, 1'b1, 8'h00);
      wait_done();
    end
    chk(rd_i == wi, "R2 frame count", rd_i, wi);

    // R9 and R10: drain timing and automatic release, 8N, 16-tick stop
    fmt_len = 2'd3; par_en = 1'b0; stop_sel = 4'd7; auto_rts_en = 1'b1;
    @(negedge clk); rts_set = 1'b1;
    @(negedge clk); rts_set = 1'b0;
    chk(rts_n == 1'b0, "R10 rts asserted", int'(rts_n), 0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'h81; exp_q[wi] = 8'h81; wi++;
    @(negedge clk); wr_valid = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (159) @(negedge clk);
    chk(tx_empty == 1'b0, "R9 busy in stop", int'(tx_empty), 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R9 empty after stop", int'(tx_empty), 1);
    repeat (15) @(negedge clk);
    chk(rts_n == 1'b0, "R10 rts held", int'(rts_n), 0);
    @(negedge clk);
    chk(rts_n == 1'b1, "R10 rts released", int'(rts_n), 1);
    wait_done();
    auto_rts_en = 1'b0;
    @(negedge clk); rts_set = 1'b1;
    @(negedge clk); rts_set = 1'b0;
    push_burst(1, 1'b1, 8'h00);
    wait_done();
    chk(rts_n == 1'b0, "R10 no auto release", int'(rts_n), 0);

    // R11: no tick, no activity
    tick16 = 1'b0;
    push_burst(1, 1'b1, 8'h00);
    burst_ok = 1;
    repeat (60) begin
      @(negedge clk);
      if (txd !== 1'b1) burst_ok = 0;
    end
    chk(burst_ok == 1, "R11 line frozen", burst_ok, 1);
    tick16 = 1'b1;
    wait_done();

    // R7: clear-to-send raised mid-character
    cts_en = 1'b1; cts_n = 1'b0;
    base = rd_i;
    push_burst(2, 1'b1, 8'h00);
    while (txd !== 1'b0) @(negedge clk);
    repeat (20) @(negedge clk);
    cts_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(rd_i == base + 1, "R7 first completes, second held", rd_i - base, 1);
    chk(tx_empty == 1'b0, "R7 held byte queued", int'(tx_empty), 0);
    cts_n = 1'b0;
    wait_done();
    chk(rd_i == base + 2, "R7 resumes", rd_i - base, 2);

    // R8: check disabled
    cts_en = 1'b0; cts_n = 1'b1;
    base = rd_i;
    push_burst(1, 1'b1, 8'h00);
    wait_done();
    chk(rd_i == base + 1, "R8 cts ignored", rd_i - base, 1);

    // R6: fill while blocked, extra write dropped
    cts_en = 1'b1; cts_n = 1'b1;
    base = rd_i;
    push_burst(DEPTH, 1'b0, 8'h10);
    chk(tx_ready == 1'b0, "R6 full", int'(tx_ready), 0);
    wr_valid = 1'b1; wr_data = 8'hA5;
    @(negedge clk); wr_valid = 1'b0;
    repeat (50) @(negedge clk);
    chk(txd == 1'b1 && rd_i == base, "R6 nothing sent while blocked", rd_i - base, 0);
    cts_n = 1'b0;
    @(negedge clk);
    while (tx_ready !== 1'b1) @(negedge clk);
    chk(tx_ready == 1'b1, "R6 space after pop", int'(tx_ready), 1);
    wait_done();
    chk(rd_i == base + DEPTH, "R6 frames drained", rd_i - base, DEPTH);
    cts_en = 1'b0;

    // R12: format change mid-character
    fmt_len = 2'd3; par_en = 1'b0; stop_sel = 4'd7;
    base = rd_i;
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hC3; exp_q[wi] = 8'hC3; wi++;
    @(negedge clk); wr_valid = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (20) @(negedge clk);
    fmt_len = 2'd0; par_en = 1'b1; stop_sel = 4'd15;
    wait_done();
    chk(rd_i == base + 1, "R12 frame kept format", rd_i - base, 1);

    finish_run();
  end
endmodule